// File: doc/BRIEF.md
# Latch-Array Checkerboard Self-Test Engine

This block tests a latch-based storage array for cells stuck at 0 or stuck at 1. A start command makes it take over the array's address, write-enable and write-data lines. It then makes four passes over the array. The first pass writes a checkerboard word to every line, and the second reads every line back and compares it. The third pass writes the inverted checkerboard, and the fourth reads and compares again. Each pass touches one line per clock, so the whole test costs 4N cycles. Because of the checkerboard, neighbouring cells always hold opposite values, and every cell is driven to both 0 and 1.

Software controls the engine and reads its results through a small register port. The results are a done flag and a pass/fail flag. For the first mismatch the engine also keeps the failing line, the pass it happened in, and which bits differed. A sticky flag records that a further mismatch followed. The sequencer state, line counter, done flag and result fields are each held in three copies behind majority voters, so one upset flop cannot corrupt them. When the engine is not running, the array's lines come straight from the functional logic.

Top module: `lcb_bist`

## Requirements
- R1: After reset, the status, address and mask registers all read zero, and the array lines follow the functional inputs.
- R2: A start runs the four passes in this order: write true pattern, read true pattern, write inverse, read inverse. Each pass steps through addresses 0 to N-1 one per cycle. The done flag is set in the cycle after the last read, exactly 4N cycles after the start is sampled.
- R3: In the true pass, bit i of the word for address a is (i mod 2) XOR a[0]. The inverse pass uses the complement. For a 16-bit word, address 0 gets 0xAAAA and address 1 gets 0x5555.
- R4: Writing bit 1 (abort) of the control word returns the engine to idle in the next cycle. Done is cleared and the array goes back to the functional inputs. Abort wins over a start in the same write.
- R5: A fault-free array completes with done=1, fail=0 and more=0.
- R6: The first mismatching read sets fail. It records the address, the pass (0 = true, 1 = inverse) and a mask equal to the read word XOR the expected word.
- R7: Each mismatch after the first sets only the sticky "more" flag. The recorded address, pass and mask keep the first failure.
- R8: While the engine runs, the functional inputs have no effect on the array lines. During read passes the write enable is low.
- R9: A start while busy is ignored and the run length is unchanged. A start from idle clears all earlier results.
- R10: The register port has a write strobe, a 2-bit select and a 2-bit write word (bit 0 = start, bit 1 = abort, select 0 only). The read data is registered and shows the selected register one cycle after the select is applied. Select 0 is status: bit0 busy, bit1 done, bit2 fail, bit3 pass, bit4 more. Select 1 is the failing address. Select 2 is the mismatch mask. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 2 | Control word: bit0 start, bit1 abort |
| reg_rdata | output | RW | Registered read data |
| fn_addr | input | AW | Functional address |
| fn_we | input | 1 | Functional write enable |
| fn_wdata | input | DW | Functional write data |
| mem_addr | output | AW | Array address |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | DW | Array write data |
| mem_rdata | input | DW | Array read data (combinational read) |

## Verification
The hardest case to reach is a mismatch that shows up only in the inverse pass, together with a second fault that must set the "more" flag without replacing the first record. The bench's array model can hold stuck-at-0 and stuck-at-1 masks per line. It places a cell stuck at the value the true pattern expects, so that cell passes in the first read pass and fails only after the inversion. A separate run places two faulty lines so that the first recorded mismatch comes from the lower address. A restart command and live functional writes are also issued in the middle of a run, and the done cycle must not move.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR0  = 3'd1,
    ST_RD0  = 3'd2,
    ST_WR1  = 3'd3,
    ST_RD1  = 3'd4
  } lcb_state_e;

endpackage

// File: rtl/lcb_tmr_reg.sv
`timescale 1ns/1ps
// Three copies of a register, each reloaded from the same next value; the
// output is the bitwise majority of the copies.
module lcb_tmr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] cp [3];

  for (genvar g = 0; g < 3; g++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst) cp[g] <= '0;
      else     cp[g] <= d;
    end
  end

  assign q = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);
endmodule

// File: rtl/lcb_seq.sv
`timescale 1ns/1ps
module lcb_seq
  import lcb_pkg::*;
#(
  parameter  int N  = 64,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  output logic          busy,
  output logic          eng_we,
  output logic          eng_cmp,
  output logic          eng_inv,
  output logic          launch,
  output logic          done,
  output logic [AW-1:0] addr
);
  localparam int SW = 1 + 3 + AW;

  lcb_state_e    st, nst;
  logic [AW-1:0] naddr;
  logic          ndone;
  logic [SW-1:0] q;
  logic          last;

  lcb_tmr_reg #(.W(SW)) u_state (
    .clk (clk),
    .rst (rst),
    .d   ({ndone, nst, naddr}),
    .q   (q)
  );

  assign done = q[SW-1];
  assign st   = lcb_state_e'(q[AW+2:AW]);
  assign addr = q[AW-1:0];
  assign last = (addr == AW'(N-1));

  assign busy    = (st != ST_IDLE);
  assign eng_we  = (st == ST_WR0) || (st == ST_WR1);
  assign eng_cmp = (st == ST_RD0) || (st == ST_RD1);
  assign eng_inv = (st == ST_WR1) || (st == ST_RD1);
  assign launch  = start && !abort && !busy;

  always_comb begin
    nst   = st;
    naddr = addr;
    ndone = done;
    if (abort) begin
      nst   = ST_IDLE;
      naddr = '0;
      ndone = 1'b0;
    end else if (launch) begin
      nst   = ST_WR0;
      naddr = '0;
      ndone = 1'b0;
    end else if (busy) begin
      if (last) begin
        naddr = '0;
        case (st)
          ST_WR0:  nst = ST_RD0;
          ST_RD0:  nst = ST_WR1;
          ST_WR1:  nst = ST_RD1;
          default: begin
            nst   = ST_IDLE;
            ndone = 1'b1;
          end
        endcase
      end else begin
        naddr = addr + AW'(1);
      end
    end
  end

  a_r4_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy && !done);

  a_r2_done_after_last_read: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(st) == ST_RD1 && $past(addr) == AW'(N-1));

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start && !abort && !last |=> busy && addr == $past(addr) + AW'(1));
endmodule

// File: rtl/lcb_capture.sv
`timescale 1ns/1ps
module lcb_capture #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          cmp_en,
  input  logic          inv,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] expect_w,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic          more,
  output logic          fphase,
  output logic [AW-1:0] faddr,
  output logic [DW-1:0] fmask
);
  localparam int CW = 3 + AW + DW;

  logic [DW-1:0] diff;
  logic          hit;
  logic          nfail, nmore, nphase;
  logic [AW-1:0] naddr;
  logic [DW-1:0] nmask;
  logic [CW-1:0] q;

  assign diff = rdata ^ expect_w;
  assign hit  = cmp_en && (diff != '0);

  always_comb begin
    nfail  = fail;
    nmore  = more;
    nphase = fphase;
    naddr  = faddr;
    nmask  = fmask;
    if (clear) begin
      nfail  = 1'b0;
      nmore  = 1'b0;
      nphase = 1'b0;
      naddr  = '0;
      nmask  = '0;
    end else if (hit) begin
      if (!fail) begin
        nfail  = 1'b1;
        nphase = inv;
        naddr  = addr;
        nmask  = diff;
      end else begin
        nmore  = 1'b1;
      end
    end
  end

  lcb_tmr_reg #(.W(CW)) u_res (
    .clk (clk),
    .rst (rst),
    .d   ({nfail, nmore, nphase, naddr, nmask}),
    .q   (q)
  );

  assign fail   = q[CW-1];
  assign more   = q[CW-2];
  assign fphase = q[CW-3];
  assign faddr  = q[DW+AW-1:DW];
  assign fmask  = q[DW-1:0];

  a_r7_more_needs_fail: assert property (@(posedge clk) disable iff (rst)
    more |-> fail);

  a_r6_capture_stable: assert property (@(posedge clk) disable iff (rst)
    fail && !clear |=> $stable(faddr) && $stable(fmask) && $stable(fphase));

  a_r6_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
    fail |-> fmask != '0);
endmodule

// File: rtl/lcb_bist.sv
`timescale 1ns/1ps
module lcb_bist #(
  parameter  int N  = 64,
  parameter  int DW = 16,
  parameter  int RW = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [1:0]    reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic [AW-1:0] fn_addr,
  input  logic          fn_we,
  input  logic [DW-1:0] fn_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          start, abort;
  logic          busy, eng_we, eng_cmp, eng_inv, launch, done;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] pat;
  logic          fail, more, fphase;
  logic [AW-1:0] faddr;
  logic [DW-1:0] fmask;

  assign start = reg_wr && (reg_sel == 2'd0) && reg_wdata[0];
  assign abort = reg_wr && (reg_sel == 2'd0) && reg_wdata[1];

  lcb_seq #(.N(N)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .abort   (abort),
    .busy    (busy),
    .eng_we  (eng_we),
    .eng_cmp (eng_cmp),
    .eng_inv (eng_inv),
    .launch  (launch),
    .done    (done),
    .addr    (eng_addr)
  );

  for (genvar i = 0; i < DW; i++) begin : g_pat
    assign pat[i] = ((i % 2) == 1) ^ eng_addr[0] ^ eng_inv;
  end

  lcb_capture #(.DW(DW), .AW(AW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clear    (launch),
    .cmp_en   (eng_cmp),
    .inv      (eng_inv),
    .addr     (eng_addr),
    .expect_w (pat),
    .rdata    (mem_rdata),
    .fail     (fail),
    .more     (more),
    .fphase   (fphase),
    .faddr    (faddr),
    .fmask    (fmask)
  );

  assign mem_addr  = busy ? eng_addr : fn_addr;
  assign mem_we    = busy ? eng_we   : fn_we;
  assign mem_wdata = busy ? pat      : fn_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        2'd0:    reg_rdata <= RW'({more, fphase, fail, done, busy});
        2'd1:    reg_rdata <= RW'(faddr);
        2'd2:    reg_rdata <= RW'(fmask);
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r8_idle_release: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mem_addr == fn_addr && mem_we == fn_we && mem_wdata == fn_wdata);

  a_r8_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
    eng_cmp |-> !mem_we);
endmodule

// File: tb/tb_lcb_bist.sv
`timescale 1ns/1ps
module tb_lcb_bist;
  localparam int N  = 64;
  localparam int DW = 16;
  localparam int RW = 32;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [1:0]    reg_wdata = 2'd0;
  logic [RW-1:0] reg_rdata;
  logic [AW-1:0] fn_addr = '0;
  logic          fn_we = 1'b0;
  logic [DW-1:0] fn_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lcb_bist #(.N(N), .DW(DW), .RW(RW)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fn_addr(fn_addr),
    .fn_we(fn_we), .fn_wdata(fn_wdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural latch array with per-line stuck-at masks.
  logic [DW-1:0] arr [N];
  logic [DW-1:0] sa0 [N];
  logic [DW-1:0] sa1 [N];

  always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;
  assign mem_rdata = (arr[mem_addr] | sa1[mem_addr]) & ~sa0[mem_addr];

  typedef struct {
    string         tag;
    logic [RW-1:0] status;
    logic [RW-1:0] faddr;
    logic [RW-1:0] fmask;
  } res_t;

  res_t exp_q[$];
  res_t obs;
  event obs_ev;

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input bit inv);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = ((i % 2) == 1) ^ ((a % 2) == 1) ^ inv;
    return p;
  endfunction

  task automatic clear_faults();
    for (int a = 0; a < N; a++) begin
      sa0[a] = '0;
      sa1[a] = '0;
    end
  endtask

  task automatic predict(input string tag, output res_t r);
    bit            f = 0;
    int            cnt = 0;
    bit            ph = 0;
    int            fa = 0;
    logic [DW-1:0] fm = '0;
    for (int inv = 0; inv < 2; inv++) begin
      for (int a = 0; a < N; a++) begin
        logic [DW-1:0] e, rd;
        e  = pat(a, inv[0]);
        rd = (e | sa1[a]) & ~sa0[a];
        if ((rd ^ e) != '0) begin
          if (!f) begin
            f = 1; ph = inv[0]; fa = a; fm = rd ^ e;
          end
          cnt++;
        end
      end
    end
    r.tag    = tag;
    r.status = RW'({(cnt > 1), ph, f, 1'b1, 1'b0});
    r.faddr  = RW'(fa);
    r.fmask  = RW'(fm);
  endtask

  task automatic reg_write(input logic [1:0] d);
    @(negedge clk);
    reg_sel = 2'd0; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 2'd0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [RW-1:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
    reg_sel = 2'd0;
  endtask

  // Monitor: pops expected results and compares them with observed ones.
  initial begin
    forever begin
      res_t e;
      @(obs_ev);
      if (exp_q.size() == 0) begin
        chk("R10 scoreboard empty", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk({e.tag, " status"}, obs.status, e.status);
        chk({e.tag, " R6 fail address"}, obs.faddr, e.faddr);
        chk({e.tag, " R6 fail mask"}, obs.fmask, e.fmask);
      end
    end
  end

  // Driver: predicts, runs one test, gathers the registers.
  task automatic run_bist(input string tag, input bit extras);
    res_t          e;
    int            m = 0;
    bit            got = 0;
    logic [RW-1:0] v;
    predict(tag, e);
    exp_q.push_back(e);
    reg_write(2'b01);
    if (extras) begin
      chk("R3 first write addr", RW'(mem_addr), 0);
      chk("R3 first write data", RW'(mem_wdata), RW'(pat(0, 0)));
      chk("R8 engine drives we", RW'(mem_we), 1);
    end
    while (!got && m < 8 * N) begin
      @(negedge clk);
      m++;
      if (extras) begin
        if (m == 1)         chk("R3 second write data", RW'(mem_wdata), RW'(pat(1, 0)));
        if (m == 10)        begin reg_wr = 1'b1; reg_wdata = 2'b01; end
        if (m == 11)        begin reg_wr = 1'b0; reg_wdata = 2'b00; end
        if (m == N + 2)     begin
          chk("R8 fn write ignored in read pass", RW'(mem_we), 0);
          chk("R2 read pass addr", RW'(mem_addr), 2);
        end
        if (m == 2 * N + 3) chk("R3 inverse write data", RW'(mem_wdata), RW'(pat(3, 1)));
      end
      if (reg_rdata[1]) got = 1;
    end
    chk({tag, " R2 R9 run length"}, RW'(m), RW'(4 * N + 1));
    obs.status = reg_rdata;
    reg_read(2'd1, v); obs.faddr = v;
    reg_read(2'd2, v); obs.fmask = v;
    ->obs_ev;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    clear_faults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", reg_rdata, 0);
    chk("R1 array follows functional addr", RW'(mem_addr), RW'(fn_addr));
    reg_read(2'd1, v); chk("R1 address reg after reset", v, 0);
    reg_read(2'd2, v); chk("R1 mask reg after reset", v, 0);
    reg_read(2'd3, v); chk("R10 unused select", v, 0);

    // Fault-free run, with functional writes and a restart during the run.
    fn_we = 1'b1; fn_addr = AW'(5); fn_wdata = '1;
    run_bist("R5 clean", 1'b1);
    fn_we = 1'b0;

    // Stuck-at-1 that fails in the true pass.
    clear_faults();
    sa1[6] = 16'h0001;
    run_bist("R6 true-pass fault", 1'b0);

    // Stuck-at-0 matching the true pattern: fails only after inversion.
    clear_faults();
    sa0[9] = 16'h0020;
    run_bist("R6 inverse-only fault", 1'b0);

    // Several faults: first one held, more flag set.
    clear_faults();
    sa1[2]  = 16'h0003;
    sa0[40] = 16'h0080;
    run_bist("R7 multi fault", 1'b0);

    // Abort mid-run; earlier results cleared by the start.
    clear_faults();
    fn_addr = AW'(17); fn_we = 1'b0;
    reg_write(2'b01);
    repeat (20) @(negedge clk);
    reg_write(2'b10);
    chk("R4 abort releases addr", RW'(mem_addr), 17);
    chk("R4 abort releases we", RW'(mem_we), 0);
    reg_read(2'd0, v);
    chk("R4 R9 status after abort", v, 0);

    // Start and abort together: abort wins.
    reg_write(2'b11);
    chk("R4 abort beats start", RW'(mem_addr), 17);
    reg_read(2'd0, v);
    chk("R4 status after start+abort", v, 0);

    // Functional access while idle.
    @(negedge clk);
    fn_addr = AW'(12); fn_wdata = 16'h1234; fn_we = 1'b1;
    @(negedge clk);
    fn_we = 1'b0;
    chk("R8 functional write and read", RW'(mem_rdata), 32'h1234);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule